// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. It decides when an embedded program or erase operation has ended, and whether that operation succeeded. After a `start` pulse it issues status reads through a request/acknowledge read port, two at a time. It keeps the toggle bit from the first read of each pair and compares it with the same bit in the second read.

If the toggle bit holds still, the operation has finished. If the bit toggles while the time-limit flag is clear, polling carries on with another pair. If the bit toggles while the flag is set, the block takes one more pair of reads to confirm, because the toggling may have stopped just as the flag rose. A failure, including a poll budget that runs out, causes one reset-command write before the failure is reported.

The outcome leaves the block as single-cycle pulses on `done`, `pass`, `fail` and `timeout`. A yield request can break off polling so that the host can do other work. The next `start` then begins again from a fresh first pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After `start` in idle, `rd_req` rises on the next cycle and stays high until `rd_ack`. The second read of a pair is requested in the cycle right after the first acknowledge.
- R2: If bit `TBIT` (bit 6 by default) is equal in both reads of a pair, `done` and `pass` are high for the cycle after the second acknowledge and no write is issued. Bit `FBIT` (bit 5 by default) has no effect on this outcome.
- R3: If the toggle bit differs and bit `FBIT` of the second read is 0, a new pair starts on the next cycle. The first read of the new pair is the new reference value.
- R4: If the toggle bit differs and bit `FBIT` of the second read is 1, one confirmation pair follows. A matching toggle bit in that pair gives `pass`, whatever `FBIT` reads.
- R5: If the confirmation pair still toggles, `wr_req` is raised with `wr_data` = 0x00F0 and held until `wr_ack`. `done` and `fail` are high for the cycle after `wr_ack`. `rd_req` and `wr_req` are never high together.
- R6: If `MAX_PAIRS` consecutive normal pairs toggle with `FBIT` low, the reset write of R5 is issued. `done`, `fail` and `timeout` are then high together for one cycle.
- R7: If `yield_req` is high when a pair ends in the keep-polling case of R3, the block goes idle with no pulse and no write. The next `start` begins with a fresh pair and a cleared poll budget.
- R8: `done` is high for exactly one cycle per completed check. Exactly one of `pass` and `fail` goes with it, and `timeout` never appears without `fail`.
- R9: `start` has no effect while a check is in progress.
- R10: While `rst_n` is low (synchronous), all outputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a completion check (used in idle only) |
| yield_req | input | 1 | Abandon polling at the next keep-polling decision |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DW | Status word returned by the device |
| wr_req | output | 1 | Reset-command write request, held until acknowledged (address is don't-care) |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | DW | Reset-command data (0x00F0) |
| done | output | 1 | One-cycle pulse: check finished |
| pass | output | 1 | One-cycle pulse: operation succeeded |
| fail | output | 1 | One-cycle pulse: operation failed, device reset |
| timeout | output | 1 | One-cycle pulse: failure caused by the poll budget |

## Verification
The bench builds the block with a 16-bit status word, the toggle bit at position 6, the flag at position 5 and `MAX_PAIRS` = 4. A budget this small lets the timeout path be reached after eight reads. It also lets the yield case show that an uncleared budget would turn a later passing check into a timeout. The non-status bits of every read carry a fixed nonzero pattern, so a design that looks at the wrong bit position gives a wrong outcome. Read and write acknowledge latencies change from scenario to scenario, which exercises both the back-to-back case and the held-request case of the handshake.

// File: rtl/tglp_pkg.sv
// Shared types for the toggle-bit completion poller.
package tglp_pkg;

    // Controller state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD_A = 2'd1,
        ST_RD_B = 2'd2,
        ST_WRST = 2'd3
    } poll_state_t;

    // Outcome passed from the FSM to the output pulse stage.
    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_PASS = 2'd1,
        RES_FAIL = 2'd2,
        RES_TMO  = 2'd3
    } poll_res_t;

endpackage

// File: rtl/tglp_bit_track.sv
// Toggle-bit tracker.
// Keeps the toggle bit of the first read of a pair. While the second read is
// acknowledged, it reports whether that bit has changed and what the flag bit reads.
// Assumes: TBIT and FBIT are distinct positions below DW.
module tglp_bit_track #(
    parameter int DW   = 16,
    parameter int TBIT = 6,
    parameter int FBIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_first,
    input  logic [DW-1:0] rd_data,
    output logic          toggled,
    output logic          flag_hi
);

    logic first_q;

    // Store the reference toggle bit on the first read of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (cap_first) begin
            first_q <= rd_data[TBIT];
        end
    end

    // Compare the current read against the stored reference.
    always_comb begin
        toggled = rd_data[TBIT] ^ first_q;
        flag_hi = rd_data[FBIT];
    end

endmodule

// File: rtl/tglp_pair_count.sv
// Poll budget counter.
// Counts normal pairs that ended in keep-polling. It raises last_pair when the
// pair now ending would use up the budget.
// Assumes: MAX_PAIRS >= 1; clr has priority over inc.
module tglp_pair_count #(
    parameter int MAX_PAIRS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_pair
);

    localparam int             CW   = $clog2(MAX_PAIRS + 1);
    localparam logic [CW-1:0]  LAST = CW'(MAX_PAIRS - 1);

    logic [CW-1:0] cnt_q;

    // Count pairs spent since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the pair that would reach the budget.
    always_comb begin
        last_pair = (cnt_q >= LAST);
    end

endmodule

// File: rtl/tglp_fsm.sv
// Sequencing FSM of the poller.
// Runs read pairs, decides pass, continue, confirm, fail or timeout, and drives
// the reset-command write. The outcome goes out on res for one cycle.
// Assumes: rd_ack and wr_ack are only high while the matching request is high.
module tglp_fsm
    import tglp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      yield_req,
    input  logic      rd_ack,
    input  logic      wr_ack,
    input  logic      toggled,
    input  logic      flag_hi,
    input  logic      last_pair,
    output logic      rd_req,
    output logic      wr_req,
    output logic      cap_first,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output poll_res_t res
);

    poll_state_t st_q, st_d;
    logic        conf_q, conf_d;
    logic        tmo_q, tmo_d;

    // State and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            conf_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            conf_q <= conf_d;
            tmo_q  <= tmo_d;
        end
    end

    // Next-state and control decode.
    always_comb begin
        st_d      = st_q;
        conf_d    = conf_q;
        tmo_d     = tmo_q;
        rd_req    = 1'b0;
        wr_req    = 1'b0;
        cap_first = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        res       = RES_NONE;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d    = ST_RD_A;
                    conf_d  = 1'b0;
                    tmo_d   = 1'b0;
                    cnt_clr = 1'b1;
                end
            end
            ST_RD_A: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    cap_first = 1'b1;
                    st_d      = ST_RD_B;
                end
            end
            ST_RD_B: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    if (!toggled) begin
                        res  = RES_PASS;
                        st_d = ST_IDLE;
                    end else if (conf_q) begin
                        tmo_d = 1'b0;
                        st_d  = ST_WRST;
                    end else if (flag_hi) begin
                        conf_d = 1'b1;
                        st_d   = ST_RD_A;
                    end else if (last_pair) begin
                        tmo_d = 1'b1;
                        st_d  = ST_WRST;
                    end else if (yield_req) begin
                        st_d = ST_IDLE;
                    end else begin
                        cnt_inc = 1'b1;
                        st_d    = ST_RD_A;
                    end
                end
            end
            ST_WRST: begin
                wr_req = 1'b1;
                if (wr_ack) begin
                    res  = tmo_q ? RES_TMO : RES_FAIL;
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/tglp_pulse_out.sv
// Output pulse stage.
// Registers the FSM outcome into one-cycle done/pass/fail/timeout pulses.
// Assumes: res is RES_NONE except for single decision cycles.
module tglp_pulse_out
    import tglp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  poll_res_t res,
    output logic      done,
    output logic      pass,
    output logic      fail,
    output logic      timeout
);

    // Turn the outcome code into registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done    <= (res != RES_NONE);
            pass    <= (res == RES_PASS);
            fail    <= (res == RES_FAIL) || (res == RES_TMO);
            timeout <= (res == RES_TMO);
        end
    end

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Toggle-bit completion poller, top level.
// Ties together the sequencing FSM, the toggle-bit tracker, the poll budget
// counter and the output pulse stage. It also drives the constant reset-command data.
// Assumes: the read and write ports follow a request-held-until-ack handshake.
module toggle_poll_ctrl #(
    parameter int          DW        = 16,
    parameter int          TBIT      = 6,
    parameter int          FBIT      = 5,
    parameter int          MAX_PAIRS = 1024,
    parameter logic [7:0]  RST_CMD   = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          yield_req,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    input  logic          wr_ack,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          timeout
);
    import tglp_pkg::*;

    localparam logic [DW-1:0] CMD_WORD = DW'(RST_CMD);

    logic      cap_first;
    logic      toggled;
    logic      flag_hi;
    logic      cnt_clr;
    logic      cnt_inc;
    logic      last_pair;
    poll_res_t res;

    tglp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .yield_req (yield_req),
        .rd_ack    (rd_ack),
        .wr_ack    (wr_ack),
        .toggled   (toggled),
        .flag_hi   (flag_hi),
        .last_pair (last_pair),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .cap_first (cap_first),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .res       (res)
    );

    tglp_bit_track #(.DW(DW), .TBIT(TBIT), .FBIT(FBIT)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_first (cap_first),
        .rd_data   (rd_data),
        .toggled   (toggled),
        .flag_hi   (flag_hi)
    );

    tglp_pair_count #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .last_pair (last_pair)
    );

    tglp_pulse_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .res     (res),
        .done    (done),
        .pass    (pass),
        .fail    (fail),
        .timeout (timeout)
    );

    // Reset-command data is constant; the address is don't-care.
    always_comb begin
        wr_data = CMD_WORD;
    end

endmodule

// File: rtl/toggle_poll_ctrl_chk.sv
// Port-level protocol and outcome checker for toggle_poll_ctrl, bound to every instance.
module toggle_poll_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic rd_ack,
    input logic wr_req,
    input logic wr_ack,
    input logic done,
    input logic pass,
    input logic fail,
    input logic timeout
);

    p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    p_pass_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> $past(rd_req && rd_ack));

    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

    p_fail_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(wr_req && wr_ack));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !wr_req);

    p_tmo_with_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> fail);

    p_single_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({pass, fail}) == 1);

    p_verdict_has_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> done);

endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .done    (done),
    .pass    (pass),
    .fail    (fail),
    .timeout (timeout)
);

// File: tb/sim_toggle_poll_ctrl.sv
// Bench: behavioural cycle model compared on every clock, plus scenario outcome checks.
module sim_toggle_poll_ctrl;

    localparam int DW = 16;
    localparam int MAXP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          yield_req = 1'b0;
    logic          rd_req;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          wr_req;
    logic          wr_ack = 1'b0;
    logic [DW-1:0] wr_data;
    logic          done, pass, fail, timeout;

    always #4 clk = ~clk;

    toggle_poll_ctrl #(.DW(DW), .TBIT(6), .FBIT(5), .MAX_PAIRS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .yield_req(yield_req),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
        .done(done), .pass(pass), .fail(fail), .timeout(timeout)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Responder state.
    logic [DW-1:0] rdq[$];
    int lat = 0, wlat = 0, rcnt = 0, wcnt = 0;
    int nreads = 0, nwr = 0, outcome = 0;

    // Reference model (0 idle, 1 reading, 2 writing).
    int m_ph = 0, m_idx = 0, m_pairs = 0;
    bit m_first = 0, m_conf = 0, m_tmo = 0;
    bit e_done = 0, e_pass = 0, e_fail = 0, e_tmo = 0;

    function automatic logic [DW-1:0] wd(input bit t, input bit f);
        return 16'h1204 | (t ? 16'h0040 : 16'h0) | (f ? 16'h0020 : 16'h0);
    endfunction

    always @(posedge clk) begin
        e_done = 0; e_pass = 0; e_fail = 0; e_tmo = 0;
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_pairs = 0; m_conf = 0; m_tmo = 0;
        end else begin
            case (m_ph)
                0: if (start) begin m_ph = 1; m_idx = 0; m_conf = 0; m_pairs = 0; end
                1: if (rd_ack) begin
                    if (m_idx == 0) begin
                        m_first = rd_data[6]; m_idx = 1;
                    end else begin
                        m_idx = 0;
                        if (rd_data[6] == m_first) begin
                            e_done = 1; e_pass = 1; m_ph = 0;
                        end else if (m_conf) begin
                            m_tmo = 0; m_ph = 2;
                        end else if (rd_data[5]) begin
                            m_conf = 1;
                        end else if (m_pairs + 1 >= MAXP) begin
                            m_tmo = 1; m_ph = 2;
                        end else if (yield_req) begin
                            m_ph = 0;
                        end else begin
                            m_pairs++;
                        end
                    end
                end
                default: if (wr_ack) begin
                    e_done = 1; e_fail = 1; e_tmo = m_tmo; m_ph = 0;
                end
            endcase
        end
    end

    // Compare, record outcome, then answer requests.
    always @(negedge clk) begin
        if (!finished) begin
            chk(rd_req == (m_ph == 1), "R1 rd_req", rd_req, m_ph == 1);
            chk(wr_req == (m_ph == 2), "R5 wr_req", wr_req, m_ph == 2);
            if (wr_req) chk(wr_data == 16'h00F0, "R5 wr_data", wr_data, 16'h00F0);
            chk(pass == e_pass, "R2 pass", pass, e_pass);
            chk(fail == e_fail, "R5 fail", fail, e_fail);
            chk(timeout == e_tmo, "R6 timeout", timeout, e_tmo);
            chk(done == e_done, "R8 done", done, e_done);
        end
        if (done) outcome = timeout ? 3 : (fail ? 2 : 1);
        if (rd_req) begin
            if (rcnt >= lat) begin
                rd_ack = 1'b1;
                rd_data = (rdq.size() > 0) ? rdq.pop_front() : wd(0, 0);
                nreads++; rcnt = 0;
            end else begin
                rd_ack = 1'b0; rcnt++;
            end
        end else begin
            rd_ack = 1'b0; rcnt = 0;
        end
        if (wr_req) begin
            if (wcnt >= wlat) begin wr_ack = 1'b1; nwr++; wcnt = 0; end
            else begin wr_ack = 1'b0; wcnt++; end
        end else begin
            wr_ack = 1'b0; wcnt = 0;
        end
    end

    task automatic go(input int l, input int wl, input int eo, input int er,
                      input int ew, input string tag);
        lat = l; wlat = wl; outcome = 0; nreads = 0; nwr = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (m_ph == 0) break;
        end
        repeat (2) @(negedge clk);
        chk(outcome == eo, {tag, " outcome"}, outcome, eo);
        chk(nreads == er, {tag, " reads"}, nreads, er);
        chk(nwr == ew, {tag, " writes"}, nwr, ew);
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=1 exp=0");
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        chk({rd_req, wr_req, done, pass, fail, timeout} == 6'b0, "R10 reset outputs",
            {rd_req, wr_req, done, pass, fail, timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: stable toggle bit, back-to-back reads
        rdq = '{wd(0, 0), wd(0, 0)};
        go(0, 0, 1, 2, 0, "R1/R2 quick pass");
        // R2: flag set but no toggle still passes
        rdq = '{wd(1, 1), wd(1, 1)};
        go(1, 0, 1, 2, 0, "R2 flag ignored");
        // R3: keep polling until stable
        rdq = '{wd(0, 0), wd(1, 0), wd(1, 0), wd(0, 0), wd(0, 0), wd(0, 0)};
        go(2, 0, 1, 6, 0, "R3 repoll");
        // R4: confirmation pair stable
        rdq = '{wd(0, 0), wd(1, 1), wd(1, 1), wd(1, 1)};
        go(1, 0, 1, 4, 0, "R4 confirm pass");
        // R5: confirmation pair still toggling
        rdq = '{wd(0, 0), wd(1, 1), wd(1, 0), wd(0, 0)};
        go(0, 3, 2, 4, 1, "R5 confirm fail");
        // R6: budget exhausted
        rdq = '{wd(0, 0), wd(1, 0), wd(1, 0), wd(0, 0), wd(0, 0), wd(1, 0), wd(1, 0), wd(0, 0)};
        go(0, 1, 3, 8, 1, "R6 timeout");
        // R7: yield at the end of the second toggling pair
        rdq = '{wd(0, 0), wd(1, 0), wd(1, 0), wd(0, 0)};
        fork
            go(2, 0, 0, 4, 0, "R7 yield");
            begin
                wait (nreads == 3);
                @(negedge clk) yield_req = 1'b1;
            end
        join
        yield_req = 1'b0;
        // R7: restart from a fresh pair with cleared budget
        rdq = '{wd(1, 0), wd(0, 0), wd(0, 0), wd(1, 0), wd(1, 0), wd(0, 0), wd(0, 0), wd(0, 0)};
        go(0, 0, 1, 8, 0, "R7 restart");
        // R9: start pulse while busy is ignored
        rdq = '{wd(0, 0), wd(1, 0), wd(1, 0), wd(1, 0)};
        fork
            go(2, 0, 1, 4, 0, "R9 start busy");
            begin
                wait (nreads == 1);
                @(negedge clk) start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
        join

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule